// File: doc/BRIEF.md
# Maskable Interrupt Flag and Enable Unit

This block collects sixteen maskable interrupt lines for a processor core. Hardware requests arrive as single-cycle pulses and are held as pending flags. Software reads and changes the pending flags, a per-line enable register, a per-line debug enable register and a global mask bit. Changes are made through one write port that can load a value, OR a mask in or AND a mask in. Bit i of each of the three per-line registers belongs to line i. Lines 0 to 13 are the general-purpose interrupts, line 14 is the data-logging interrupt and line 15 is the real-time operating-system interrupt.

The unit decides which pending lines are allowed to interrupt. In normal operation a line needs the global mask clear and its enable bit set. While the core is halted in real-time debug mode, a line needs its enable bit and its debug enable bit set, and the global mask is ignored. Among the allowed lines the lowest index wins. The unit drives a request flag and the winning line number.

The core answers with a one-cycle acknowledge that carries a line number and a type. A hardware service or a software interrupt instruction clears that line's flag. A trap instruction leaves the flag set.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset the pending flags, the enable register and the debug enable register are all zero, the global mask reads 1, and `irq_o` is 0.
- R2: A pulse on `hw_req_i[i]` sets pending flag bit i, and the bit reads back as 1 from the next cycle on (`reg_sel_i` = 0 reads flags, 1 reads enable, 2 reads debug enable, 3 reads the mask in bit 0).
- R3: A write with `wr_op_i` = 0 loads the selected register, `wr_op_i` = 1 ORs `wr_data_i` into it, and `wr_op_i` = 2 ANDs `wr_data_i` into it. An AND-write of zero to the flags clears every pending flag.
- R4: When a set from a hardware pulse and a clear from an AND-write or an acknowledge hit the same flag bit in the same cycle, the bit ends up set.
- R5: With `rt_halt_i` = 0, a pending line is allowed only if the global mask is 0 and its enable bit is 1.
- R6: With `rt_halt_i` = 1, a pending line is allowed if its enable bit and its debug enable bit are both 1, whatever the global mask holds.
- R7: `irq_o` is 1 whenever any line is allowed, and `irq_idx_o` then gives the lowest allowed index. Both follow the register state in the same cycle.
- R8: An acknowledge with `ack_type_i` = 0 (hardware service) or 1 (software interrupt) clears flag bit `ack_idx_i` at the next edge.
- R9: An acknowledge with `ack_type_i` = 2 (trap) leaves flag bit `ack_idx_i` unchanged.
- R10: While `irq_o` is 0, `irq_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_req_i | input | 16 | Hardware request pulses, one bit per line |
| rt_halt_i | input | 1 | Core is halted in real-time debug mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_op_i | input | 2 | Write operation: 0 load, 1 OR, 2 AND |
| reg_sel_i | input | 2 | Register select for write and read |
| wr_data_i | input | 16 | Write data or mask |
| rd_data_o | output | 16 | Selected register contents |
| ack_i | input | 1 | One-cycle acknowledge from the core |
| ack_type_i | input | 2 | Acknowledge type: 0 hardware, 1 software interrupt, 2 trap |
| ack_idx_i | input | 4 | Line number being acknowledged |
| irq_o | output | 1 | An allowed interrupt is pending |
| irq_idx_o | output | 4 | Lowest allowed pending line |

## Verification
A new hardware pulse can land on the same flag bit, in the same cycle, as a software AND-write or a clearing acknowledge. The bench provokes both collisions. It drives a line's request together with an AND-write of zero, and a line's request together with a hardware-service acknowledge of that same line. In each case it reads the flag register in the next idle cycle and expects the bit to be set. The bench then checks that a later plain clear does remove the bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ACK_HW   = 2'd0,
    ACK_SWI  = 2'd1,
    ACK_TRAP = 2'd2
  } ack_type_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_OR   = 2'd1,
    OP_AND  = 2'd2
  } wr_op_e;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_IEN  = 2'd1,
    SEL_DBG  = 2'd2,
    SEL_MASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_pkg::*;
#(
  parameter int N_LINES = 16,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] hw_req_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_op_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [N_LINES-1:0] wr_data_i,
  input  logic               ack_i,
  input  logic [1:0]         ack_type_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  output logic [N_LINES-1:0] flags_o,
  output logic [N_LINES-1:0] ien_o,
  output logic [N_LINES-1:0] dbg_o,
  output logic               mask_o
);
  localparam logic [N_LINES-1:0] ONE = {{(N_LINES-1){1'b0}}, 1'b1};

  logic [N_LINES-1:0] flags_q, ien_q, dbg_q;
  logic [N_LINES-1:0] flags_d, ien_d, dbg_d;
  logic               mask_q, mask_d;
  logic [N_LINES-1:0] ack_bit, ack_clr;

  function automatic logic [N_LINES-1:0] apply_op(
    input logic [1:0] op, input logic [N_LINES-1:0] cur, input logic [N_LINES-1:0] data);
    case (op)
      OP_OR:   apply_op = cur | data;
      OP_AND:  apply_op = cur & data;
      OP_LOAD: apply_op = data;
      default: apply_op = cur;
    endcase
  endfunction

  assign ack_bit = ONE << ack_idx_i;
  assign ack_clr = (ack_i && (ack_type_i == ACK_HW || ack_type_i == ACK_SWI)) ? ack_bit : '0;

  always_comb begin
    flags_d = flags_q & ~ack_clr;
    ien_d   = ien_q;
    dbg_d   = dbg_q;
    mask_d  = mask_q;
    if (wr_en_i) begin
      case (reg_sel_i)
        SEL_FLAG: flags_d = apply_op(wr_op_i, flags_d, wr_data_i);
        SEL_IEN:  ien_d   = apply_op(wr_op_i, ien_q, wr_data_i);
        SEL_DBG:  dbg_d   = apply_op(wr_op_i, dbg_q, wr_data_i);
        default: begin
          case (wr_op_i)
            OP_OR:   mask_d = mask_q | wr_data_i[0];
            OP_AND:  mask_d = mask_q & wr_data_i[0];
            OP_LOAD: mask_d = wr_data_i[0];
            default: mask_d = mask_q;
          endcase
        end
      endcase
    end
    // new requests override any clear in the same cycle
    flags_d = flags_d | hw_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      ien_q   <= '0;
      dbg_q   <= '0;
      mask_q  <= 1'b1;
    end else begin
      flags_q <= flags_d;
      ien_q   <= ien_d;
      dbg_q   <= dbg_d;
      mask_q  <= mask_d;
    end
  end

  assign flags_o = flags_q;
  assign ien_o   = ien_q;
  assign dbg_o   = dbg_q;
  assign mask_o  = mask_q;

  assert_req_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_req_i) |=> ((flags_q & $past(hw_req_i)) == $past(hw_req_i)));

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (|(hw_req_i & ack_bit))) |=> ((flags_q & $past(ack_bit)) != '0));

  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_type_i != ACK_TRAP && !wr_en_i && !(|(hw_req_i & ack_bit)))
    |=> ((flags_q & $past(ack_bit)) == '0));

  assert_trap_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_type_i == ACK_TRAP && !wr_en_i && (|(flags_q & ack_bit)))
    |=> ((flags_q & $past(ack_bit)) != '0));
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int N_LINES = 16
) (
  input  logic [N_LINES-1:0] flags_i,
  input  logic [N_LINES-1:0] ien_i,
  input  logic [N_LINES-1:0] dbg_i,
  input  logic               mask_i,
  input  logic               rt_halt_i,
  output logic [N_LINES-1:0] allowed_o
);
  logic [N_LINES-1:0] gate;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    // halted real-time mode swaps the global mask for the per-line debug enable
    assign gate[i]      = rt_halt_i ? dbg_i[i] : ~mask_i;
    assign allowed_o[i] = flags_i[i] & ien_i[i] & gate[i];
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N_LINES = 16,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] allowed_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (allowed_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |allowed_i;
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_pkg::*;
#(
  parameter int N_LINES = 16,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] hw_req_i,
  input  logic               rt_halt_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_op_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [N_LINES-1:0] wr_data_i,
  output logic [N_LINES-1:0] rd_data_o,
  input  logic               ack_i,
  input  logic [1:0]         ack_type_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   irq_idx_o
);
  logic [N_LINES-1:0] flags, ien, dbg, allowed;
  logic               mask;

  irq_flag_regs #(.N_LINES(N_LINES)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_req_i   (hw_req_i),
    .wr_en_i    (wr_en_i),
    .wr_op_i    (wr_op_i),
    .reg_sel_i  (reg_sel_i),
    .wr_data_i  (wr_data_i),
    .ack_i      (ack_i),
    .ack_type_i (ack_type_i),
    .ack_idx_i  (ack_idx_i),
    .flags_o    (flags),
    .ien_o      (ien),
    .dbg_o      (dbg),
    .mask_o     (mask)
  );

  irq_qualify #(.N_LINES(N_LINES)) u_qual (
    .flags_i   (flags),
    .ien_i     (ien),
    .dbg_i     (dbg),
    .mask_i    (mask),
    .rt_halt_i (rt_halt_i),
    .allowed_o (allowed)
  );

  irq_prio #(.N_LINES(N_LINES)) u_prio (
    .allowed_i (allowed),
    .valid_o   (irq_o),
    .idx_o     (irq_idx_o)
  );

  always_comb begin
    case (reg_sel_i)
      SEL_FLAG: rd_data_o = flags;
      SEL_IEN:  rd_data_o = ien;
      SEL_DBG:  rd_data_o = dbg;
      default:  rd_data_o = {{(N_LINES-1){1'b0}}, mask};
    endcase
  end

  assert_mask_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rt_halt_i) |-> (!mask && ien[irq_idx_o] && flags[irq_idx_o]));

  assert_dbg_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && rt_halt_i) |-> (dbg[irq_idx_o] && ien[irq_idx_o] && flags[irq_idx_o]));

  assert_lowest_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((allowed & ((N_LINES'(1) << irq_idx_o) - N_LINES'(1))) == '0));

  assert_idle_idx_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_idx_o == '0));
endmodule

// File: tb/sim_irq_flag_unit.sv
module sim_irq_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hw_req;
  logic        rt_halt;
  logic        wr_en;
  logic [1:0]  wr_op;
  logic [1:0]  reg_sel;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        ack;
  logic [1:0]  ack_type;
  logic [3:0]  ack_idx;
  logic        irq;
  logic [3:0]  irq_idx;

  always #4 clk = ~clk;

  irq_flag_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .rt_halt_i(rt_halt),
    .wr_en_i(wr_en), .wr_op_i(wr_op), .reg_sel_i(reg_sel), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ack_i(ack), .ack_type_i(ack_type), .ack_idx_i(ack_idx),
    .irq_o(irq), .irq_idx_o(irq_idx)
  );

  typedef struct {
    string       tag;
    logic [15:0] rd;
    logic        irq;
    logic [3:0]  idx;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;

  // monitor: compare at the falling edge, before the driver changes inputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (rd_data !== e.rd || irq !== e.irq || irq_idx !== e.idx) begin
        n_bad++;
        $display("FAIL %s: rd=%h irq=%b idx=%0d expected rd=%h irq=%b idx=%0d",
                 e.tag, rd_data, irq, irq_idx, e.rd, e.irq, e.idx);
      end
    end
  end

  task automatic idle();
    hw_req = '0; wr_en = 0; wr_op = 0; reg_sel = 0; wr_data = '0;
    ack = 0; ack_type = 0; ack_idx = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] op, input logic [15:0] d,
                    input logic [15:0] req = '0);
    @(negedge clk); #1; idle();
    wr_en = 1; reg_sel = sel; wr_op = op; wr_data = d; hw_req = req;
  endtask

  task automatic pulse(input logic [15:0] req);
    @(negedge clk); #1; idle();
    hw_req = req;
  endtask

  task automatic do_ack(input logic [1:0] t, input logic [3:0] i, input logic [15:0] req = '0);
    @(negedge clk); #1; idle();
    ack = 1; ack_type = t; ack_idx = i; hw_req = req;
  endtask

  task automatic chk(input string tag, input logic [1:0] sel, input logic [15:0] rd,
                     input logic ex_irq, input logic [3:0] ex_idx);
    exp_t e;
    @(negedge clk); #1; idle();
    reg_sel = sel;
    e.tag = tag; e.rd = rd; e.irq = ex_irq; e.idx = ex_idx;
    exp_q.push_back(e);
  endtask

  bit done = 0;

  initial begin
    idle();
    rt_halt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    chk("R1 flags", 0, 16'h0000, 0, 0);
    chk("R1 enable", 1, 16'h0000, 0, 0);
    chk("R1 debug enable", 2, 16'h0000, 0, 0);
    chk("R1 mask", 3, 16'h0001, 0, 0);

    pulse(16'h0120);
    chk("R2 pulses latched, mask set", 0, 16'h0120, 0, 0);

    wr(1, 0, 16'h0100);
    wr(3, 0, 16'h0000);
    chk("R5 enable+mask clear", 0, 16'h0120, 1, 8);
    wr(1, 1, 16'h0020);
    chk("R7 lower index wins", 1, 16'h0120, 1, 5);
    wr(3, 1, 16'h0001);
    chk("R5 mask blocks", 3, 16'h0001, 0, 0);

    wr(2, 0, 16'h0100);
    rt_halt = 1;
    chk("R6 halted ignores mask", 2, 16'h0100, 1, 8);
    wr(2, 2, 16'h0000);
    chk("R6 no debug enable", 2, 16'h0000, 0, 0);
    rt_halt = 0;
    wr(3, 2, 16'h0000);

    do_ack(0, 5);
    chk("R8 hw service clears", 0, 16'h0100, 1, 8);
    do_ack(2, 8);
    chk("R9 trap keeps flag", 0, 16'h0100, 1, 8);
    do_ack(1, 8);
    chk("R8 swi clears, R10 idle idx", 0, 16'h0000, 0, 0);

    wr(0, 1, 16'h8001);
    chk("R3 or-write, R10 none enabled", 0, 16'h8001, 0, 0);
    wr(1, 1, 16'h8000);
    chk("R7 top line alone", 1, 16'h8120, 1, 15);
    wr(0, 2, 16'h8000);
    chk("R3 and-write", 0, 16'h8000, 1, 15);
    wr(0, 2, 16'h0000, 16'h8000);
    chk("R4 pulse beats and-write", 0, 16'h8000, 1, 15);
    wr(0, 2, 16'h0000);
    chk("R3 and-zero clears all", 0, 16'h0000, 0, 0);

    do_ack(0, 3, 16'h0008);
    chk("R4 pulse beats ack", 0, 16'h0008, 0, 0);
    wr(0, 0, 16'hFFFF);
    chk("R3 load write", 0, 16'hFFFF, 1, 5);

    @(negedge clk); #1; idle();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL queue: %0d left, expected 0", exp_q.size());
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule